// File: doc/BRIEF.md
# DMA Context Control Register Bank

This block keeps the control and status word of four asynchronous DMA contexts, two that transmit and two that receive. Software starts and stops a context, and asks a stalled context to resume, by writing to the host register port. Each context has two write addresses. At the first address every 1 bit in the data sets a bit. At the second address every 1 bit clears a bit. A read from either address returns the current word of that context.

The context engine sits beside the bank and reports events on per-context strobes: a descriptor fetch, a fatal error, the start and end of descriptor processing, and a packet completion that carries a speed code and an event code. Two side effects link the bits. A fetch drops the resume request. A software stop also clears the error flag and the busy flag. The engine reads the run and resume bits directly from dedicated outputs.

Top module: `dma_ctx_ctrl_bank`

## Requirements
- R1: Context k (0..3) has its set address at 0x180 + 0x20*k and its clear address at that address + 4. A read of either address returns the context word. Any other address reads 0, and a write to it changes no context.
- R2: Bits 31:16, 14:13 and 9:8 of every context word always read 0, even after a write of all ones.
- R3: Run (bit 15) becomes 1 when a set-address write has data bit 15 high. It becomes 0 when a clear-address write has data bit 15 high. Data bits that are 0 leave it unchanged, and no hardware strobe changes it.
- R4: Wake (bit 12) becomes 1 when a set-address write has data bit 12 high. A fetch strobe clears it. If both happen in the same cycle, the software set wins. A clear-address write has no effect on wake.
- R5: Dead (bit 11) becomes 1 on a fatal strobe. A clear-address write that clears run also clears dead, and this wins over a fatal strobe in the same cycle. Software cannot write dead in any other way.
- R6: Active (bit 10) becomes 1 on a busy strobe, but only while run is 1. An idle strobe clears it. Busy wins over idle in the same cycle. A run-clear write clears active and wins over both strobes.
- R7: A done strobe loads the event code (bits 4:0). On receive contexts 2 and 3 it also loads the speed code (bits 7:5; 000 = 100, 001 = 200, 010 = 400 Mb/s). On transmit contexts 0 and 1 the speed field always reads 000. Software writes do not change either field.
- R8: While rst_n is low at a clock edge, every field of every context becomes 0, and so do the run and wake outputs.
- R9: ctx_run[k] and ctx_wake[k] always equal bits 15 and 12 of context k's word. Every register update takes effect at the clock edge that samples the write or strobe, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wr | input | 1 | Write strobe for reg_addr/reg_wdata |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| hw_fetch | input | 4 | Per-context descriptor fetch strobe |
| hw_fatal | input | 4 | Per-context fatal error strobe |
| hw_busy | input | 4 | Per-context start-of-processing strobe |
| hw_idle | input | 4 | Per-context end-of-processing strobe |
| hw_done | input | 4 | Per-context packet completion strobe |
| hw_spd | input | 12 | Speed codes, 3 bits per context, context 0 in the low bits |
| hw_evt | input | 20 | Event codes, 5 bits per context, context 0 in the low bits |
| ctx_run | output | 4 | Run bit of each context |
| ctx_wake | output | 4 | Wake bit of each context |

## Verification
The assertions assume that reset is held low for at least one clock edge, and that reg_addr is valid whenever reg_wr is high. They also assume that a strobe is seen as a single-cycle event at each edge where it is high. No assumption is made about how strobes on different contexts, or a strobe and a write, line up in time. For that reason the stimulus draws every strobe independently each cycle and aims most writes at the eight mapped addresses. This places collisions such as fetch with a wake set, fatal with a run clear, and busy with idle many times in one run. Directed cycles then force each of those collisions once, with known expected words.

// File: rtl/ctxctl_pkg.sv
// Shared types for the DMA context control bank.
// Holds the stored fields of one context and the function that places them
// in the 32-bit readback word. Reserved positions are always zero.
package ctxctl_pkg;

    typedef struct packed {
        logic       run;
        logic       wake;
        logic       dead;
        logic       active;
        logic [2:0] spd;
        logic [4:0] evt;
    } ctx_word_t;

    // Place the stored fields at their readback positions
    function automatic logic [31:0] pack_word(input ctx_word_t w);
        return {16'h0000, w.run, 2'b00, w.wake, w.dead, w.active, 2'b00, w.spd, w.evt};
    endfunction

endpackage

// File: rtl/ctxctl_decode.sv
// Address decoder for the context bank.
// Maps a byte address onto a context index and onto a set or clear slot.
// Assumes BASE_ADDR is a multiple of the stride and NUM_CTX >= 2.
module ctxctl_decode #(
    parameter int ADDR_W    = 12,
    parameter int NUM_CTX   = 4,
    parameter int BASE_ADDR = 'h180,
    parameter int STRIDE_LG = 5,
    parameter int CLR_OFS   = 4
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_en,
    output logic [NUM_CTX-1:0]         set_hit,
    output logic [NUM_CTX-1:0]         clr_hit,
    output logic                       rd_hit,
    output logic [$clog2(NUM_CTX)-1:0] rd_idx
);
    localparam int IDX_W = $clog2(NUM_CTX);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(NUM_CTX << STRIDE_LG);

    logic [ADDR_W-1:0]    off;
    logic                 in_win;
    logic [STRIDE_LG-1:0] sub;
    logic                 is_set;
    logic                 is_clr;

    // Window offset and slot within a context stride
    always_comb begin
        off    = addr - BASE_V;
        in_win = (addr >= BASE_V) && (off < SPAN_V);
        sub    = off[STRIDE_LG-1:0];
        rd_idx = off[STRIDE_LG +: IDX_W];
        is_set = in_win && (sub == '0);
        is_clr = in_win && (sub == STRIDE_LG'(CLR_OFS));
        rd_hit = is_set || is_clr;
    end

    // Per-context write strobes
    always_comb begin
        for (int k = 0; k < NUM_CTX; k++) begin
            set_hit[k] = wr_en && is_set && (rd_idx == IDX_W'(k));
            clr_hit[k] = wr_en && is_clr && (rd_idx == IDX_W'(k));
        end
    end

    // At most one context slot accepts a given write
    always_comb begin
        AST_ONE_WRITE_TARGET: assert ($onehot0({set_hit, clr_hit}));  // R1
    end

endmodule

// File: rtl/ctxctl_slot.sv
// Control/status storage for one DMA context.
// Applies software set/clear strobes and engine strobes with fixed priorities.
// Assumes the write strobes are already qualified by the address decode.
// IS_RX selects whether the speed field is stored or held at zero.
module ctxctl_slot
    import ctxctl_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_run_set,
    input  logic      sw_run_clr,
    input  logic      sw_wake_set,
    input  logic      hw_fetch,
    input  logic      hw_fatal,
    input  logic      hw_busy,
    input  logic      hw_idle,
    input  logic      hw_done,
    input  logic [2:0] hw_spd,
    input  logic [4:0] hw_evt,
    output ctx_word_t word
);
    logic       run_q;
    logic       wake_q;
    logic       dead_q;
    logic       active_q;
    logic [2:0] spd_q;
    logic [4:0] evt_q;

    // Run: software owned, cleared only by reset or the clear address
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (sw_run_set) run_q <= 1'b1;
        else if (sw_run_clr) run_q <= 1'b0;
    end

    // Wake: software set beats a same-cycle fetch clear
    always_ff @(posedge clk) begin
        if (!rst_n)           wake_q <= 1'b0;
        else if (sw_wake_set) wake_q <= 1'b1;
        else if (hw_fetch)    wake_q <= 1'b0;
    end

    // Dead: fatal sets, a software stop clears and wins
    always_ff @(posedge clk) begin
        if (!rst_n)          dead_q <= 1'b0;
        else if (sw_run_clr) dead_q <= 1'b0;
        else if (hw_fatal)   dead_q <= 1'b1;
    end

    // Active: busy sets while running, idle or a stop clears
    always_ff @(posedge clk) begin
        if (!rst_n)                  active_q <= 1'b0;
        else if (sw_run_clr)         active_q <= 1'b0;
        else if (hw_busy && run_q)   active_q <= 1'b1;
        else if (hw_idle)            active_q <= 1'b0;
    end

    // Event code: captured on every completion
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_q <= '0;
        else if (hw_done) evt_q <= hw_evt;
    end

    generate
        if (IS_RX) begin : g_rx_spd
            // Speed code: captured on completion for receive contexts
            always_ff @(posedge clk) begin
                if (!rst_n)       spd_q <= '0;
                else if (hw_done) spd_q <= hw_spd;
            end
        end else begin : g_tx_spd
            logic unused_spd;
            assign unused_spd = ^hw_spd;
            assign spd_q = 3'b000;
        end
    endgenerate

    assign word = '{run: run_q, wake: wake_q, dead: dead_q, active: active_q,
                    spd: spd_q, evt: evt_q};

    AST_RUN_ONLY_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_run_set && !sw_run_clr) |=> (run_q == $past(run_q)));  // R3

    AST_WAKE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wake_set |=> wake_q);  // R4

    AST_FETCH_DROPS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_fetch && !sw_wake_set) |=> !wake_q);  // R4

    AST_STOP_CLEARS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        sw_run_clr |=> (!dead_q && !run_q));  // R5

    AST_STOP_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_run_clr |=> !active_q);  // R6

    AST_NO_BUSY_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !active_q) |=> !active_q);  // R6

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_done |=> ($stable(evt_q) && $stable(spd_q)));  // R7

endmodule

// File: rtl/dma_ctx_ctrl_bank.sv
// Register bank holding the control/status word of several DMA contexts.
// Each context has a write-one-to-set and a write-one-to-clear address.
// Reads are combinational from either address. Unmapped reads return zero.
// Contexts with index >= NUM_TX are receive contexts and store a speed code.
module dma_ctx_ctrl_bank
    import ctxctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_CTX   = 4,
    parameter int NUM_TX    = 2,
    parameter int BASE_ADDR = 'h180,
    parameter int STRIDE_LG = 5,
    parameter int CLR_OFS   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_CTX-1:0]    hw_fetch,
    input  logic [NUM_CTX-1:0]    hw_fatal,
    input  logic [NUM_CTX-1:0]    hw_busy,
    input  logic [NUM_CTX-1:0]    hw_idle,
    input  logic [NUM_CTX-1:0]    hw_done,
    input  logic [NUM_CTX*3-1:0]  hw_spd,
    input  logic [NUM_CTX*5-1:0]  hw_evt,
    output logic [NUM_CTX-1:0]    ctx_run,
    output logic [NUM_CTX-1:0]    ctx_wake
);
    localparam int IDX_W    = $clog2(NUM_CTX);
    localparam int RUN_BIT  = 15;
    localparam int WAKE_BIT = 12;

    logic [NUM_CTX-1:0] set_hit;
    logic [NUM_CTX-1:0] clr_hit;
    logic               rd_hit;
    logic [IDX_W-1:0]   rd_idx;
    ctx_word_t          words [NUM_CTX];

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[14:13], reg_wdata[11:0]};

    ctxctl_decode #(
        .ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX), .BASE_ADDR(BASE_ADDR),
        .STRIDE_LG(STRIDE_LG), .CLR_OFS(CLR_OFS)
    ) u_decode (
        .addr(reg_addr), .wr_en(reg_wr),
        .set_hit(set_hit), .clr_hit(clr_hit),
        .rd_hit(rd_hit), .rd_idx(rd_idx)
    );

    generate
        for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
            ctxctl_slot #(.IS_RX(k >= NUM_TX)) u_slot (
                .clk(clk), .rst_n(rst_n),
                .sw_run_set (set_hit[k] && reg_wdata[RUN_BIT]),
                .sw_run_clr (clr_hit[k] && reg_wdata[RUN_BIT]),
                .sw_wake_set(set_hit[k] && reg_wdata[WAKE_BIT]),
                .hw_fetch(hw_fetch[k]), .hw_fatal(hw_fatal[k]),
                .hw_busy(hw_busy[k]), .hw_idle(hw_idle[k]), .hw_done(hw_done[k]),
                .hw_spd(hw_spd[k*3 +: 3]), .hw_evt(hw_evt[k*5 +: 5]),
                .word(words[k])
            );
            assign ctx_run[k]  = words[k].run;
            assign ctx_wake[k] = words[k].wake;
        end
    endgenerate

    // Readback multiplexer over the selected context
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CTX; k++) begin
            if (rd_hit && (rd_idx == IDX_W'(k))) reg_rdata = pack_word(words[k]);
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((reg_rdata[31:16] == 16'h0) && (reg_rdata[14:13] == 2'b00)
                  && (reg_rdata[9:8] == 2'b00)));  // R2

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (reg_rdata == 32'h0));  // R1

    AST_RESET_CLEARS_OUTPUTS: assert property (@(posedge clk)
        !rst_n |=> ((ctx_run == '0) && (ctx_wake == '0)));  // R8

endmodule

// File: tb/dma_ctx_ctrl_bank_bench.sv
module dma_ctx_ctrl_bank_bench;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  hw_fetch, hw_fatal, hw_busy, hw_idle, hw_done;
    logic [11:0] hw_spd;
    logic [19:0] hw_evt;
    logic [3:0]  ctx_run, ctx_wake;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // bench model of every context
    bit       m_run [NC];
    bit       m_wake[NC];
    bit       m_dead[NC];
    bit       m_act [NC];
    bit [2:0] m_spd [NC];
    bit [4:0] m_evt [NC];

    always #2 clk = ~clk;

    dma_ctx_ctrl_bank u_dma_ctx_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_fetch(hw_fetch), .hw_fatal(hw_fatal), .hw_busy(hw_busy),
        .hw_idle(hw_idle), .hw_done(hw_done), .hw_spd(hw_spd), .hw_evt(hw_evt),
        .ctx_run(ctx_run), .ctx_wake(ctx_wake)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: -1 for unmapped, else index; kind 0 = set, 1 = clear
    function automatic int ctx_of(input logic [11:0] a, output int kind);
        kind = 0;
        for (int k = 0; k < NC; k++) begin
            if (a == 12'(12'h180 + k*32)) begin kind = 0; return k; end
            if (a == 12'(12'h184 + k*32)) begin kind = 1; return k; end
        end
        return -1;
    endfunction

    // R2: reserved bits are zero in the expected word
    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int kind;
        int k = ctx_of(a, kind);
        if (k < 0) return 32'h0;
        return {16'h0, m_run[k], 2'b00, m_wake[k], m_dead[k], m_act[k], 2'b00,
                m_spd[k], m_evt[k]};
    endfunction

    function automatic logic [3:0] exp_run();
        logic [3:0] v;
        for (int k = 0; k < NC; k++) v[k] = m_run[k];
        return v;
    endfunction

    function automatic logic [3:0] exp_wake();
        logic [3:0] v;
        for (int k = 0; k < NC; k++) v[k] = m_wake[k];
        return v;
    endfunction

    // Apply one edge worth of inputs to the model (R3..R7 priorities)
    task automatic model_edge();
        int kind;
        int t = reg_wr ? ctx_of(reg_addr, kind) : -1;
        for (int k = 0; k < NC; k++) begin
            bit sw_set = (t == k) && (kind == 0);
            bit sw_clr = (t == k) && (kind == 1);
            bit stop   = sw_clr && reg_wdata[15];
            bit old_run = m_run[k];
            if (sw_set && reg_wdata[15]) m_run[k] = 1'b1;
            else if (stop)               m_run[k] = 1'b0;
            if (sw_set && reg_wdata[12]) m_wake[k] = 1'b1;
            else if (hw_fetch[k])        m_wake[k] = 1'b0;
            if (stop)                    m_dead[k] = 1'b0;
            else if (hw_fatal[k])        m_dead[k] = 1'b1;
            if (stop)                          m_act[k] = 1'b0;
            else if (hw_busy[k] && old_run)    m_act[k] = 1'b1;
            else if (hw_idle[k])               m_act[k] = 1'b0;
            if (hw_done[k]) begin
                m_evt[k] = hw_evt[k*5 +: 5];
                m_spd[k] = (k >= 2) ? hw_spd[k*3 +: 3] : 3'b000;
            end
        end
    endtask

    // One cycle: drive, compare pre-edge readback and outputs, clock, update model
    task automatic step(input logic [11:0] a, input bit w, input logic [31:0] d,
                        input logic [3:0] f, input logic [3:0] fa, input logic [3:0] b,
                        input logic [3:0] id, input logic [3:0] dn,
                        input logic [11:0] sp, input logic [19:0] ev);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d;
        hw_fetch = f; hw_fatal = fa; hw_busy = b; hw_idle = id; hw_done = dn;
        hw_spd = sp; hw_evt = ev;
        #1;
        check(reg_rdata == exp_read(a), "R1 R2 R3 R4 R5 R6 R7 readback", reg_rdata, exp_read(a));
        check({ctx_run, ctx_wake} == {exp_run(), exp_wake()}, "R9 run/wake outputs",
              {24'h0, ctx_run, ctx_wake}, {24'h0, exp_run(), exp_wake()});
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle_step(input logic [11:0] a);
        step(a, 1'b0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 12'h0, 20'h0);
    endtask

    // Read without any input activity and compare to a fixed value
    task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0; reg_wdata = '0;
        hw_fetch = '0; hw_fatal = '0; hw_busy = '0; hw_idle = '0; hw_done = '0;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd7805));
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        hw_fetch = '0; hw_fatal = '0; hw_busy = '0; hw_idle = '0; hw_done = '0;
        hw_spd = '0; hw_evt = '0;
        for (int k = 0; k < NC; k++) begin
            m_run[k] = 0; m_wake[k] = 0; m_dead[k] = 0; m_act[k] = 0;
            m_spd[k] = 0; m_evt[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8: reset state
        peek(12'h1E4, 32'h0, "R8 reset word");
        check({ctx_run, ctx_wake} == 8'h00, "R8 reset outputs", {24'h0, ctx_run, ctx_wake}, 32'h0);

        // R2 R3 R4: all-ones write to context 2 set address
        step(12'h1C0, 1'b1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
        peek(12'h1C4, 32'h0000_9000, "R2 R3 R4 all-ones set write");
        // R4: fetch clears wake, then set beats a same-cycle fetch
        step(12'h1C0, 1'b0, 0, 4'b0100, 0, 0, 0, 0, 0, 0);
        peek(12'h1C0, 32'h0000_8000, "R4 fetch clears wake");
        step(12'h1C0, 1'b1, 32'h0000_1000, 4'b0100, 0, 0, 0, 0, 0, 0);
        peek(12'h1C0, 32'h0000_9000, "R4 set wins over fetch");
        // R4: clear address does not touch wake; R3: zero bits leave run
        step(12'h1C4, 1'b1, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 0);
        peek(12'h1C0, 32'h0000_9000, "R3 R4 clear address ignores wake");
        // R6: busy ignored while stopped, taken while running; busy beats idle
        step(12'h180, 1'b0, 0, 0, 0, 4'b0101, 0, 0, 0, 0);
        peek(12'h180, 32'h0, "R6 busy ignored while stopped");
        peek(12'h1C0, 32'h0000_9400, "R6 busy sets active");
        step(12'h1C0, 1'b0, 0, 0, 0, 4'b0100, 4'b0100, 0, 0, 0);
        peek(12'h1C0, 32'h0000_9400, "R6 busy wins over idle");
        // R5: fatal sets dead; stop beats same-cycle fatal, also clears active
        step(12'h1C0, 1'b0, 0, 0, 4'b0100, 0, 0, 0, 0, 0);
        peek(12'h1C0, 32'h0000_9C00, "R5 fatal sets dead");
        step(12'h1C4, 1'b1, 32'h0000_8000, 0, 4'b0100, 4'b0100, 0, 0, 0, 0);
        peek(12'h1C0, 32'h0000_1000, "R5 R6 stop clears dead and active");
        // R7: done strobes on a transmit and a receive context
        step(12'h180, 1'b0, 0, 0, 0, 0, 0, 4'b1001, 12'b010_000_000_010,
             {5'h0D, 5'h00, 5'h00, 5'h11});
        peek(12'h180, 32'h0000_0011, "R7 transmit speed reads zero");
        peek(12'h1E4, 32'h0000_004D, "R7 receive speed and event");
        // R7 R5: software cannot write speed, event or dead
        step(12'h1E0, 1'b1, 32'h0000_08E0, 0, 0, 0, 0, 0, 0, 0);
        peek(12'h1E0, 32'h0000_004D, "R5 R7 software writes ignored");
        // R1: writes inside the window but off the slots change nothing
        step(12'h1C8, 1'b1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
        peek(12'h1C8, 32'h0, "R1 off-slot read is zero");
        peek(12'h1C0, 32'h0000_1000, "R1 off-slot write ignored");
        step(12'h200, 1'b1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
        peek(12'h1A0, 32'h0, "R1 out-of-window write ignored");

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 10);
            logic [11:0] a;
            if (r < 8) a = 12'(12'h180 + (r / 2) * 32 + (r % 2) * 4);
            else       a = 12'($urandom);
            step(a, 1'($urandom), $urandom,
                 4'($urandom & $urandom), 4'($urandom & $urandom & $urandom),
                 4'($urandom & $urandom), 4'($urandom & $urandom),
                 4'($urandom & $urandom), 12'($urandom), 20'($urandom));
        end
        for (int k = 0; k < NC; k++) idle_step(12'(12'h180 + k * 32));

        // R8: reset mid-run clears everything again
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < NC; k++) peek(12'(12'h184 + k * 32), 32'h0, "R8 reset after traffic");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R9 actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule